// File: doc/BRIEF.md
# Collision Presence Signal Generator

This block drives the collision-presence pair toward the attached terminal equipment. It makes a square tone of about 10 MHz by counting cycles of the system clock and gates that tone onto two complementary legs, `cd_p` and `cd_n`. The tone is sent whenever any of three sources asks for it. The first is a medium collision flag from the analog comparator. The second is the jabber flag from the transmit watchdog. The third is a short self-test burst, the heartbeat, that the block times itself after each transmission ends.

With no source active, both legs sit low, which is the zero-differential idle state. Each time the tone starts, its phase counter starts from zero, so the first high pulse on `cd_p` always has its full width. The heartbeat sequencer watches `tx_valid` for the end of a frame. It waits a fixed delay, then asks for the tone for a fixed length of time. If a new frame starts during the wait, the pending burst is dropped. `heartbeat_enable` switches the self-test burst off for systems that must not see it. It does not affect collision or jabber signalling.

With the default parameters and a 200 MHz clock, the tone period is 20 cycles (100 ns), so each high pulse lasts 50 ns. The burst starts about 1.1 µs after the frame ends and lasts 1 µs.

Top module: `collision_presence_gen`

## Requirements
- R1: While `rst` is high, and at any time when no source has been active, `cd_p`, `cd_n` and `cd_active` are all 0.
- R2: When `collision_detect` is sampled high on a rising edge, `cd_active` is 1 after that edge. `cd_p` is then 1 for TONE_HALF_CYCLES edges (default 10), and after that `cd_n` is 1 for TONE_HALF_CYCLES edges. This pattern repeats with a period of 2*TONE_HALF_CYCLES cycles.
- R3: `jabber_active` alone produces the same tone. When one source takes over from another with no idle cycle in between, the tone continues in phase and does not restart.
- R4: Every activation after an idle cycle begins with `cd_p` high for a full TONE_HALF_CYCLES edges. No cut-short pulse ever ends while the tone is still active.
- R5: `cd_p` and `cd_n` are never 1 together. When no source is sampled active on an edge, all three outputs are 0 after that edge.
- R6: Edge 0 is the first rising edge that samples `tx_valid` low after it was high, with `heartbeat_enable` high. Counting from edge 0, `cd_active` first becomes 1 after edge HB_DELAY_CYCLES+1 (default 221). The first pulse of the burst is on `cd_p`.
- R7: With no other source active, the heartbeat keeps `cd_active` at 1 for exactly HB_BURST_CYCLES consecutive cycles (default 200). `cd_active` is 0 after edge HB_DELAY_CYCLES+HB_BURST_CYCLES+1.
- R8: While `heartbeat_enable` is low, no heartbeat burst occurs. Lowering it while a burst is pending cancels that burst.
- R9: If `tx_valid` is sampled high again while a burst is pending, that burst never appears. The next burst is timed from the next end of transmission.
- R10: `collision_detect` and `jabber_active` produce the tone whatever the level of `heartbeat_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the tone is divided from it |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | High while the local transmitter is sending a frame |
| collision_detect | input | 1 | Medium collision flag from the analog comparator |
| jabber_active | input | 1 | Transmit watchdog has tripped |
| heartbeat_enable | input | 1 | High allows the post-transmission self-test burst |
| cd_p | output | 1 | Positive leg of the tone pair |
| cd_n | output | 1 | Negative leg of the tone pair |
| cd_active | output | 1 | High while a tone is being sent |

## Verification
Assertions check the following on every cycle: both legs low when the tone is off, the legs never high together, the tone starting on the positive leg, the positive pulse never longer than half a period and never cut short while the tone runs, and the response of the output one cycle after the sources change. In the sequencer, assertions also bound the wait count and the burst length, and check that a new frame or a cleared enable clears a pending burst. Only the bench scenarios show the absolute timing of the burst measured from the end of a frame at the ports, the correct phase at chosen points of the tone, and a tone that continues when one source hands over to another. The same holds for the whole-window absence of a burst when the enable is cleared or a new frame starts early.

// File: rtl/cpg_pkg.sv
`timescale 1ns/1ps
package cpg_pkg;

    // Heartbeat sequencer states
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_BURST = 2'd2
    } hb_state_e;

    // Sources that may ask for the tone
    typedef struct packed {
        logic collision;
        logic jabber;
        logic heartbeat;
    } cd_src_t;

    // Registered drive of the output pair
    typedef struct packed {
        logic p;
        logic n;
        logic active;
    } cd_drive_t;

    localparam cd_drive_t DRIVE_IDLE = '{p: 1'b0, n: 1'b0, active: 1'b0};

    function automatic logic any_source(input cd_src_t s);
        return s.collision | s.jabber | s.heartbeat;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cpg_tx_edge.sv
`timescale 1ns/1ps
module cpg_tx_edge (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    output logic tx_end
);

    logic tx_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_prev <= 1'b0;
        end else begin
            tx_prev <= tx_valid;
        end
    end

    // End of frame: was sending on the last edge, not sending now
    assign tx_end = tx_prev & ~tx_valid;

endmodule

// File: rtl/cpg_hb_seq.sv
`timescale 1ns/1ps
module cpg_hb_seq
    import cpg_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 220,
    parameter int unsigned BURST_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic tx_end,
    input  logic hb_enable,
    output logic hb_burst
);

    localparam int unsigned CW = $clog2(max_u(DELAY_CYCLES, BURST_CYCLES) + 1);
    localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_CYCLES - 1);
    localparam logic [CW-1:0] BURST_LAST = CW'(BURST_CYCLES - 1);

    hb_state_e      state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            HB_IDLE: begin
                if (tx_end && hb_enable) begin
                    state_nx = HB_WAIT;
                    cnt_nx   = '0;
                end
            end
            HB_WAIT: begin
                if (!hb_enable || tx_valid) begin
                    state_nx = HB_IDLE;
                    cnt_nx   = '0;
                end else if (cnt == DELAY_LAST) begin
                    state_nx = HB_BURST;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            HB_BURST: begin
                if (!hb_enable) begin
                    state_nx = HB_IDLE;
                    cnt_nx   = '0;
                end else if (tx_end) begin
                    state_nx = HB_WAIT;
                    cnt_nx   = '0;
                end else if (cnt == BURST_LAST) begin
                    state_nx = HB_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = HB_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HB_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign hb_burst = (state == HB_BURST);

    // Independent occupancy counters for the checks below
    logic [CW-1:0] chk_wait;
    logic [CW-1:0] chk_burst;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_wait  <= '0;
            chk_burst <= '0;
        end else begin
            chk_wait  <= (state == HB_WAIT)  ? chk_wait  + 1'b1 : '0;
            chk_burst <= (state == HB_BURST) ? chk_burst + 1'b1 : '0;
        end
    end

    p_delay_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(hb_burst) |-> chk_wait == CW'(DELAY_CYCLES));

    p_burst_len_r7: assert property (@(posedge clk) disable iff (rst)
        hb_burst |-> chk_burst < CW'(BURST_CYCLES));

    p_suppress_r8: assert property (@(posedge clk) disable iff (rst)
        !hb_enable |=> state == HB_IDLE);

    p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
        (state == HB_WAIT && tx_valid) |=> state == HB_IDLE);

endmodule

// File: rtl/cpg_tone_gen.sv
`timescale 1ns/1ps
module cpg_tone_gen
    import cpg_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic cd_p,
    output logic cd_n,
    output logic cd_active
);

    localparam int unsigned PERIOD = 2 * HALF_CYCLES;
    localparam int unsigned PW     = $clog2(PERIOD);
    localparam int unsigned HW     = $clog2(HALF_CYCLES + 1);
    localparam logic [PW-1:0] HALF_V = PW'(HALF_CYCLES);
    localparam logic [PW-1:0] LAST_V = PW'(PERIOD - 1);

    logic [PW-1:0] phase;
    cd_drive_t     drv;

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            phase <= '0;
            drv   <= DRIVE_IDLE;
        end else begin
            drv.p      <= (phase <  HALF_V);
            drv.n      <= (phase >= HALF_V);
            drv.active <= 1'b1;
            phase      <= (phase == LAST_V) ? '0 : phase + 1'b1;
        end
    end

    assign cd_p      = drv.p;
    assign cd_n      = drv.n;
    assign cd_active = drv.active;

    // Length of the current high run on the positive leg
    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else begin
            hi_run <= cd_p ? hi_run + 1'b1 : '0;
        end
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !cd_active |-> (!cd_p && !cd_n));

    p_pulse_max_r2: assert property (@(posedge clk) disable iff (rst)
        cd_p |-> hi_run < HW'(HALF_CYCLES));

    p_first_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cd_active) |-> cd_p);

    p_pulse_full_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(cd_p) && cd_active) |-> hi_run == HW'(HALF_CYCLES));

    p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(cd_p && cd_n));

endmodule

// File: rtl/collision_presence_gen.sv
`timescale 1ns/1ps
module collision_presence_gen
    import cpg_pkg::*;
#(
    parameter int unsigned TONE_HALF_CYCLES = 10,
    parameter int unsigned HB_DELAY_CYCLES  = 220,
    parameter int unsigned HB_BURST_CYCLES  = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic collision_detect,
    input  logic jabber_active,
    input  logic heartbeat_enable,
    output logic cd_p,
    output logic cd_n,
    output logic cd_active
);

    logic    tx_end;
    logic    hb_burst;
    cd_src_t src;
    logic    tone_req;

    cpg_tx_edge u_tx_edge (
        .clk      (clk),
        .rst      (rst),
        .tx_valid (tx_valid),
        .tx_end   (tx_end)
    );

    cpg_hb_seq #(
        .DELAY_CYCLES (HB_DELAY_CYCLES),
        .BURST_CYCLES (HB_BURST_CYCLES)
    ) u_hb_seq (
        .clk       (clk),
        .rst       (rst),
        .tx_valid  (tx_valid),
        .tx_end    (tx_end),
        .hb_enable (heartbeat_enable),
        .hb_burst  (hb_burst)
    );

    always_comb begin
        src.collision = collision_detect;
        src.jabber    = jabber_active;
        src.heartbeat = hb_burst;
        tone_req      = any_source(src);
    end

    cpg_tone_gen #(
        .HALF_CYCLES (TONE_HALF_CYCLES)
    ) u_tone_gen (
        .clk       (clk),
        .rst       (rst),
        .req       (tone_req),
        .cd_p      (cd_p),
        .cd_n      (cd_n),
        .cd_active (cd_active)
    );

    // Collision or jabber turns the tone on at the next edge (also covers R3, R10)
    p_src_on_r2: assert property (@(posedge clk) disable iff (rst)
        (collision_detect || jabber_active) |=> cd_active);

    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !(collision_detect || jabber_active || hb_burst) |=> !cd_active);

endmodule

// File: tb/collision_presence_gen_bench.sv
`timescale 1ns/1ps
module collision_presence_gen_bench;

    localparam int HALF = 10;
    localparam int DLY  = 220;
    localparam int LEN  = 200;

    typedef struct packed {
        logic       coll;
        logic       jab;
        logic       hbe;
        logic [7:0] wait_n;
        logic       act;
        logic       p;
        logic       n;
        logic [3:0] req;
    } vec_t;

    // Inputs applied at a falling edge, outputs checked wait_n falling edges later
    localparam vec_t VECS [13] = '{
        '{1'b0, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd2},
        '{1'b1, 1'b0, 1'b1, 8'd9,  1'b1, 1'b1, 1'b0, 4'd4},
        '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 1'b1, 4'd2},
        '{1'b1, 1'b0, 1'b1, 8'd9,  1'b1, 1'b0, 1'b1, 4'd2},
        '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd2},
        '{1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b0, 1'b0, 1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b0, 1'b1, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd3},
        '{1'b0, 1'b1, 1'b1, 8'd12, 1'b1, 1'b0, 1'b1, 4'd3},
        '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0, 1'b1, 4'd10},
        '{1'b1, 1'b0, 1'b0, 8'd10, 1'b1, 1'b1, 1'b0, 4'd10},
        '{1'b0, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 1'b0, 4'd5}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0;
    logic coll = 1'b0;
    logic jab = 1'b0;
    logic hbe = 1'b1;
    logic cd_p, cd_n, cd_active;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    collision_presence_gen #(
        .TONE_HALF_CYCLES (HALF),
        .HB_DELAY_CYCLES  (DLY),
        .HB_BURST_CYCLES  (LEN)
    ) u_collision_presence_gen (
        .clk              (clk),
        .rst              (rst),
        .tx_valid         (tx_valid),
        .collision_detect (coll),
        .jabber_active    (jab),
        .heartbeat_enable (hbe),
        .cd_p             (cd_p),
        .cd_n             (cd_n),
        .cd_active        (cd_active)
    );

    task automatic check_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic ea, input logic ep, input logic en);
        check_int({tag, " cd_active"}, int'(cd_active), int'(ea));
        check_int({tag, " cd_p"},      int'(cd_p),      int'(ep));
        check_int({tag, " cd_n"},      int'(cd_n),      int'(en));
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watch cd_active for span falling edges; report first high index, high count, cd_p at first
    task automatic measure(input int span, output int first, output int count, output int p_first);
        first = -1; count = 0; p_first = 0;
        for (int k = 1; k <= span; k++) begin
            @(negedge clk);
            if (cd_active === 1'b1) begin
                count++;
                if (first < 0) begin
                    first = k;
                    p_first = int'(cd_p);
                end
            end
        end
    endtask

    task automatic tx_frame();
        tx_valid = 1'b1;
        step(5);
        tx_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int first, count, pf;

        // R1: reset holds outputs low even with a source asserted
        step(1);
        coll = 1'b1;
        step(4);
        check_out("R1 reset", 1'b0, 1'b0, 1'b0);
        rst  = 1'b0;
        coll = 1'b0;
        step(3);
        check_out("R1 idle after reset", 1'b0, 1'b0, 1'b0);

        // Table walk: tone phase, sources, merge, idle return
        for (int i = 0; i < 13; i++) begin
            coll = VECS[i].coll;
            jab  = VECS[i].jab;
            hbe  = VECS[i].hbe;
            step(int'(VECS[i].wait_n));
            check_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                      VECS[i].act, VECS[i].p, VECS[i].n);
        end
        hbe = 1'b1;
        coll = 1'b0;
        jab = 1'b0;
        step(3);

        // R6 / R7: heartbeat timing and length
        tx_frame();
        measure(DLY + LEN + 30, first, count, pf);
        check_int("R6 heartbeat start", first, DLY + 2);
        check_int("R7 heartbeat length", count, LEN);
        check_int("R4 heartbeat first on cd_p", pf, 1);

        // R8: enable low suppresses the burst
        hbe = 1'b0;
        tx_frame();
        measure(DLY + LEN + 30, first, count, pf);
        check_int("R8 disabled burst", count, 0);

        // R8: clearing enable while pending cancels
        hbe = 1'b1;
        tx_frame();
        measure(100, first, count, pf);
        check_int("R8 before clear", count, 0);
        hbe = 1'b0;
        measure(DLY + LEN, first, count, pf);
        check_int("R8 cleared while pending", count, 0);
        hbe = 1'b1;
        step(2);

        // R9: a new frame during the wait cancels, next end restarts timing
        tx_frame();
        measure(100, first, count, pf);
        check_int("R9 wait before new frame", count, 0);
        tx_frame();
        measure(DLY + LEN + 30, first, count, pf);
        check_int("R9 retimed start", first, DLY + 2);
        check_int("R9 single burst length", count, LEN);

        // R10: collision with enable low still signals
        hbe  = 1'b0;
        coll = 1'b1;
        step(1);
        check_out("R10 collision with enable low", 1'b1, 1'b1, 1'b0);
        coll = 1'b0;
        step(1);
        check_out("R5 drop to idle", 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule